// File: doc/BRIEF.md
# Frame check sequence generator and checker

This block computes a 16-bit cyclic redundancy check over the bytes of short radio MAC frames. The frames run from the first header byte to the end of the payload; the length byte is not part of them. The block holds two independent engines. The transmit engine lies in the byte stream going out of the MAC. It forwards every frame byte without change. When automatic append is enabled, it then inserts the two check bytes after the final payload byte. The receive engine watches the incoming byte stream, including the two trailing check bytes. At the end of each frame it latches a pass or fail flag.

Each octet is processed least-significant bit first, because that bit goes out first in time. The remainder starts at zero for every frame and is never inverted. The check bytes go out low byte first, so remainder bit 0 is transmitted first. A received frame passes when the remainder over all of its bytes, check bytes included, is zero.

The transmit side has a valid/ready input and a valid/ready output, and each carries first and last markers. A byte moves on an edge where both valid and ready are high. In pass-through, input ready follows output ready. While the check bytes are being inserted, input ready is held low. An offered output byte keeps its value until it is taken. The receive side is a sink with no ready: every byte presented with `rx_valid` high is consumed.

Top module: `fcs_engine`

## Requirements
- R1: The remainder uses the generator x^16 + x^12 + x^5 + 1 and takes each byte bit 0 first. It restarts from zero at each frame and has no final inversion. Bit i of the check value is the remainder coefficient sent i-th. For the three bytes 0x02, 0x00, 0x6A, the appended bytes are 0xE4 and then 0x79.
- R2: Outside an append, `tx_out_valid`, `tx_out_data` and `tx_out_first` equal their inputs, and `tx_in_ready` equals `tx_out_ready`.
- R3: When a byte with `tx_in_last` is accepted while `auto_fcs_en` is 1, it leaves with `tx_out_last` = 0. Two more bytes follow: the low check byte with last = 0, then the high check byte with last = 1. Neither has first set.
- R4: While the two check bytes are offered, `tx_in_ready` is 0 and the offered byte stays unchanged until `tx_out_ready` takes it.
- R5: When `auto_fcs_en` is 0 as the last byte is accepted, that byte leaves with `tx_out_last` = 1 and nothing is inserted; the frame passes through unchanged.
- R6: A byte accepted with its first marker restarts the remainder on either side, even if the previous frame never saw a last byte. A byte with both first and last set forms a frame by itself.
- R7: One cycle after the receive side accepts a last byte, `rx_crc_ok` is 1 exactly when the remainder over the whole frame, check bytes included, is zero.
- R8: `rx_crc_ok` is 0 after reset. It holds its value until the next first byte is accepted, which clears it unless that byte is also last. Bytes with `rx_valid` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_fcs_en | input | 1 | Insert check bytes after each transmitted frame |
| tx_in_valid | input | 1 | Transmit input byte offered |
| tx_in_ready | output | 1 | Transmit input byte can be taken |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_first | input | 1 | Byte opens a frame |
| tx_in_last | input | 1 | Byte closes the payload |
| tx_out_valid | output | 1 | Transmit output byte offered |
| tx_out_ready | input | 1 | Downstream takes the output byte |
| tx_out_data | output | 8 | Transmit output byte |
| tx_out_first | output | 1 | Output byte opens a frame |
| tx_out_last | output | 1 | Output byte closes the frame |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Received byte opens a frame |
| rx_last | input | 1 | Received byte closes the frame |
| rx_crc_ok | output | 1 | Last received frame passed the check |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 16-bit remainder and the polynomial 0x1021. With these values the append runs through both index values of the two-byte insertion. The reflected division can then be compared against a plain long-division model of the generator. Random output stalls land in both pass-through and insertion. Aborted frames and one-byte frames, together with corrupted and gapped received frames, exercise the restart and hold rules.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_CRC_W  = 16;
  localparam logic [DEF_CRC_W-1:0] DEF_POLY = 16'h1021;

  typedef enum logic [0:0] {
    TX_PASS   = 1'b0,
    TX_APPEND = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc #(
  parameter int BYTE_W = fcs_pkg::DEF_BYTE_W,
  parameter int CRC_W  = fcs_pkg::DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY = fcs_pkg::DEF_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              restart,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_next
);
  function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] POLY_R = mirror(POLY);

  logic [CRC_W-1:0] crc_q;

  // shift right: register bit 0 is the coefficient that leaves first
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = restart ? '0 : crc_q;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ POLY_R;
    end
    crc_next = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (step_en) crc_q <= crc_next;
  end
endmodule

// File: rtl/fcs_tx_append.sv
module fcs_tx_append #(
  parameter int BYTE_W = fcs_pkg::DEF_BYTE_W,
  parameter int CRC_W  = fcs_pkg::DEF_CRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  input  logic [CRC_W-1:0]  crc_next,
  output logic              accept,
  output logic              appending
);
  import fcs_pkg::*;

  localparam int NB    = CRC_W / BYTE_W;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NB - 1);

  tx_mode_e         mode_q;
  logic [IDX_W-1:0] idx_q;
  logic [CRC_W-1:0] fcs_q;
  logic [CRC_W-1:0] fcs_sh;

  assign appending = (mode_q == TX_APPEND);
  assign accept    = in_valid && in_ready;
  assign fcs_sh    = fcs_q >> (int'(idx_q) * BYTE_W);

  always_comb begin
    if (appending) begin
      out_valid = 1'b1;
      out_data  = fcs_sh[BYTE_W-1:0];
      out_first = 1'b0;
      out_last  = (idx_q == IDX_LAST);
      in_ready  = 1'b0;
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
      out_first = in_first;
      out_last  = in_last && !auto_en;
      in_ready  = out_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TX_PASS;
      idx_q  <= '0;
      fcs_q  <= '0;
    end else if (!appending) begin
      if (accept && in_last && auto_en) begin
        mode_q <= TX_APPEND;
        idx_q  <= '0;
        fcs_q  <= crc_next;
      end
    end else if (out_ready) begin
      if (idx_q == IDX_LAST) mode_q <= TX_PASS;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/fcs_rx_check.sv
module fcs_rx_check #(
  parameter int CRC_W = fcs_pkg::DEF_CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic             rx_last,
  input  logic [CRC_W-1:0] crc_next,
  output logic             crc_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  crc_ok <= 1'b0;
    else if (rx_valid && rx_last)  crc_ok <= (crc_next == '0);
    else if (rx_valid && rx_first) crc_ok <= 1'b0;
  end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine #(
  parameter int BYTE_W = fcs_pkg::DEF_BYTE_W,
  parameter int CRC_W  = fcs_pkg::DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY = fcs_pkg::DEF_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_fcs_en,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [BYTE_W-1:0] tx_in_data,
  input  logic              tx_in_first,
  input  logic              tx_in_last,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  output logic              tx_out_first,
  output logic              tx_out_last,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_first,
  input  logic              rx_last,
  output logic              rx_crc_ok
);
  logic [CRC_W-1:0] tx_crc_next;
  logic [CRC_W-1:0] rx_crc_next;
  logic             tx_accept;
  logic             tx_appending;

  fcs_crc_acc #(.BYTE_W(BYTE_W), .CRC_W(CRC_W), .POLY(POLY)) i_tx_acc (
    .clk(clk), .rst_n(rst_n), .step_en(tx_accept), .restart(tx_in_first),
    .din(tx_in_data), .crc_next(tx_crc_next)
  );

  fcs_tx_append #(.BYTE_W(BYTE_W), .CRC_W(CRC_W)) i_tx_app (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_fcs_en),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .in_first(tx_in_first), .in_last(tx_in_last),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .out_first(tx_out_first), .out_last(tx_out_last),
    .crc_next(tx_crc_next), .accept(tx_accept), .appending(tx_appending)
  );

  fcs_crc_acc #(.BYTE_W(BYTE_W), .CRC_W(CRC_W), .POLY(POLY)) i_rx_acc (
    .clk(clk), .rst_n(rst_n), .step_en(rx_valid), .restart(rx_first),
    .din(rx_data), .crc_next(rx_crc_next)
  );

  fcs_rx_check #(.CRC_W(CRC_W)) i_rx_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_last(rx_last), .crc_next(rx_crc_next), .crc_ok(rx_crc_ok)
  );
endmodule

// File: rtl/fcs_engine_sva.sv
module fcs_engine_sva #(
  parameter int BYTE_W = fcs_pkg::DEF_BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_fcs_en,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic              tx_in_last,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [BYTE_W-1:0] tx_out_data,
  input logic              tx_out_first,
  input logic              tx_out_last,
  input logic              tx_appending,
  input logic              rx_valid,
  input logic              rx_first,
  input logic              rx_last,
  input logic              rx_crc_ok
);
  assert_pass_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_appending |-> (tx_in_ready == tx_out_ready && tx_out_valid == tx_in_valid));

  assert_append_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && tx_in_last && auto_fcs_en)
      |=> (tx_appending && tx_out_valid && !tx_out_first));

  assert_input_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_appending |-> !tx_in_ready);

  assert_stall_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_appending && !tx_out_ready)
      |=> (tx_out_valid && $stable(tx_out_data) && $stable(tx_out_last)));

  assert_no_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && tx_in_last && !auto_fcs_en) |=> !tx_appending);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && (rx_first || rx_last)) |=> $stable(rx_crc_ok));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first && !rx_last) |=> !rx_crc_ok);
endmodule

bind fcs_engine fcs_engine_sva #(.BYTE_W(BYTE_W)) i_fcs_engine_sva (
  .clk(clk), .rst_n(rst_n), .auto_fcs_en(auto_fcs_en),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_last(tx_in_last),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
  .tx_out_first(tx_out_first), .tx_out_last(tx_out_last), .tx_appending(tx_appending),
  .rx_valid(rx_valid), .rx_first(rx_first), .rx_last(rx_last), .rx_crc_ok(rx_crc_ok)
);

// File: tb/test_fcs_engine.sv
module test_fcs_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_fcs_en = 1'b0;
  logic       tx_in_valid = 1'b0;
  logic       tx_in_ready;
  logic [7:0] tx_in_data = '0;
  logic       tx_in_first = 1'b0;
  logic       tx_in_last = 1'b0;
  logic       tx_out_valid;
  logic       tx_out_ready = 1'b1;
  logic [7:0] tx_out_data;
  logic       tx_out_first;
  logic       tx_out_last;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_first = 1'b0;
  logic       rx_last = 1'b0;
  logic       rx_crc_ok;

  fcs_engine i_fcs_engine (
    .clk(clk), .rst_n(rst_n), .auto_fcs_en(auto_fcs_en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_in_first(tx_in_first), .tx_in_last(tx_in_last),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_out_first(tx_out_first), .tx_out_last(tx_out_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first), .rx_last(rx_last),
    .rx_crc_ok(rx_crc_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit running = 0;
  bit stall_mode = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // plain long division by x^16+x^12+x^5+1 of (message * x^16), bits in send order
  function automatic logic [15:0] long_div(input logic [7:0] msg[$]);
    logic [16:0] rem = '0;
    foreach (msg[i]) begin
      for (int b = 0; b < 8; b++) begin
        rem = {rem[15:0], msg[i][b]};
        if (rem[16]) rem = rem ^ 17'h11021;
      end
    end
    for (int z = 0; z < 16; z++) begin
      rem = {rem[15:0], 1'b0};
      if (rem[16]) rem = rem ^ 17'h11021;
    end
    return rem[15:0];
  endfunction

  // bit i = remainder coefficient sent i-th
  function automatic logic [15:0] ref_fcs(input logic [7:0] msg[$]);
    logic [15:0] r = long_div(msg);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = r[15-i];
    return o;
  endfunction

  // ---------------- cycle reference model ----------------
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] cap[$];
  bit         m_app = 0;
  int         m_idx = 0;
  logic [15:0] m_fcs = '0;
  bit         m_ok = 0;

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(rx_crc_ok == m_ok, "R7/R8 rx status flag", 32'(rx_crc_ok), 32'(m_ok));
      if (rx_valid) begin
        if (rx_first) rxq = {};
        rxq.push_back(rx_data);
        if (rx_last) m_ok = (long_div(rxq) == 16'h0);
        else if (rx_first) m_ok = 0;
      end

      if (!m_app) begin
        chk(tx_out_valid == tx_in_valid, "R2 out valid mirrors input", 32'(tx_out_valid), 32'(tx_in_valid));
        chk(tx_in_ready == tx_out_ready, "R2 in ready mirrors out ready", 32'(tx_in_ready), 32'(tx_out_ready));
        if (tx_in_valid) begin
          chk(tx_out_data == tx_in_data, "R2 data pass", 32'(tx_out_data), 32'(tx_in_data));
          chk(tx_out_first == tx_in_first, "R2 first pass", 32'(tx_out_first), 32'(tx_in_first));
          if (tx_in_last && auto_fcs_en)
            chk(tx_out_last == 1'b0, "R3 payload last hidden", 32'(tx_out_last), 32'd0);
          else
            chk(tx_out_last == tx_in_last, "R5 last marker pass", 32'(tx_out_last), 32'(tx_in_last));
        end
        if (tx_in_valid && tx_in_ready) begin
          if (tx_in_first) txq = {};
          txq.push_back(tx_in_data);
          if (tx_in_last && auto_fcs_en) begin
            m_fcs = ref_fcs(txq);
            m_app = 1;
            m_idx = 0;
          end
        end
      end else begin
        chk(tx_out_valid == 1'b1, "R3 check byte offered", 32'(tx_out_valid), 32'd1);
        chk(tx_in_ready == 1'b0, "R4 input held off", 32'(tx_in_ready), 32'd0);
        chk(tx_out_data == (m_idx == 0 ? m_fcs[7:0] : m_fcs[15:8]), "R1 check byte value",
            32'(tx_out_data), 32'(m_idx == 0 ? m_fcs[7:0] : m_fcs[15:8]));
        chk(tx_out_first == 1'b0, "R3 no first on check byte", 32'(tx_out_first), 32'd0);
        chk(tx_out_last == (m_idx == 1), "R3 last on high byte", 32'(tx_out_last), 32'(m_idx == 1));
        if (tx_out_ready) begin
          cap.push_back(tx_out_data);
          m_idx++;
          if (m_idx == 2) m_app = 0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      tx_out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // ---------------- drivers ----------------
  task automatic tx_byte(input logic [7:0] d, input bit f, input bit l);
    bit r;
    tx_in_valid = 1; tx_in_data = d; tx_in_first = f; tx_in_last = l;
    forever begin
      @(negedge clk); r = tx_in_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    tx_in_valid = 0; tx_in_data = 8'($urandom);
    tx_in_first = 1'($urandom); tx_in_last = 1'($urandom);
    if (stall_mode && ($urandom % 3 == 0)) begin @(posedge clk); #1; end
    tx_in_first = 0; tx_in_last = 0;
  endtask

  task automatic tx_frame(input logic [7:0] q[$], input bit en);
    auto_fcs_en = en;
    foreach (q[i]) tx_byte(q[i], i == 0, i == q.size() - 1);
  endtask

  task automatic rx_frame(input logic [7:0] q[$], input bit gaps);
    foreach (q[i]) begin
      rx_valid = 1; rx_data = q[i]; rx_first = (i == 0); rx_last = (i == q.size() - 1);
      @(posedge clk); #1;
      if (gaps && ($urandom % 2 == 0)) begin
        rx_valid = 0; rx_data = 8'($urandom);
        rx_first = 1'($urandom); rx_last = 1'($urandom);
        @(posedge clk); #1;
      end
    end
    rx_valid = 0; rx_first = 0; rx_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic void rand_frame(ref logic [7:0] q[$], input int n);
    q = {};
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] f[$];
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rx_crc_ok == 1'b0, "R8 flag low in reset", 32'(rx_crc_ok), 32'd0);
    chk(tx_out_valid == 1'b0, "R2 no output in reset", 32'(tx_out_valid), 32'd0);
    @(posedge clk); #1;
    rst_n = 1;
    idle(1);
    chk(rx_crc_ok == 1'b0, "R8 flag low after reset", 32'(rx_crc_ok), 32'd0);
    running = 1;

    // R1: worked example
    cap = {};
    tx_frame('{8'h02, 8'h00, 8'h6A}, 1);
    idle(4);
    chk(cap.size() == 2, "R3 two check bytes", 32'(cap.size()), 32'd2);
    if (cap.size() == 2) begin
      chk(cap[0] == 8'hE4, "R1 example low byte", 32'(cap[0]), 32'hE4);
      chk(cap[1] == 8'h79, "R1 example high byte", 32'(cap[1]), 32'h79);
    end

    // R5: no append, next frame right behind
    cap = {};
    tx_frame('{8'h11, 8'h22, 8'h33}, 0);
    tx_frame('{8'h44}, 0);
    idle(2);
    chk(cap.size() == 0, "R5 nothing inserted", 32'(cap.size()), 32'd0);

    // R6: aborted frame then single-byte frame with append
    tx_byte(8'hA5, 1, 0);
    tx_byte(8'h5A, 0, 0);
    cap = {};
    tx_frame('{8'h3C}, 1);
    idle(4);
    q = '{8'h3C};
    v = ref_fcs(q);
    chk(cap.size() == 2 && cap[0] == v[7:0], "R6 restart after abort", 32'(cap.size() == 2 ? cap[0] : 8'h00), 32'(v[7:0]));

    // R2-R4 under random stalls
    stall_mode = 1;
    for (int k = 0; k < 40; k++) begin
      rand_frame(q, 1 + ($urandom % 20));
      tx_frame(q, 1'($urandom));
    end
    idle(6);
    stall_mode = 0;
    idle(2);

    // R7: example received frame
    rx_frame('{8'h02, 8'h00, 8'h6A, 8'hE4, 8'h79}, 0);
    @(negedge clk);
    chk(rx_crc_ok == 1'b1, "R7 example frame passes", 32'(rx_crc_ok), 32'd1);
    @(posedge clk); #1;
    // R8: invalid bytes carrying markers change nothing
    rx_valid = 0; rx_first = 1; rx_last = 1; rx_data = 8'hFF;
    idle(3);
    rx_first = 0; rx_last = 0;
    @(negedge clk);
    chk(rx_crc_ok == 1'b1, "R8 flag held across idle", 32'(rx_crc_ok), 32'd1);
    @(posedge clk); #1;
    rx_frame('{8'h02, 8'h01, 8'h6A, 8'hE4, 8'h79}, 0);
    @(negedge clk);
    chk(rx_crc_ok == 1'b0, "R7 corrupted frame fails", 32'(rx_crc_ok), 32'd0);
    @(posedge clk); #1;
    rx_frame('{8'h00}, 0);
    @(negedge clk);
    chk(rx_crc_ok == 1'b1, "R6 single zero byte frame", 32'(rx_crc_ok), 32'd1);
    @(posedge clk); #1;

    for (int k = 0; k < 60; k++) begin
      rand_frame(q, 1 + ($urandom % 16));
      v = ref_fcs(q);
      f = q;
      f.push_back(v[7:0]);
      f.push_back(v[15:8]);
      if ($urandom % 3 == 0) f[$urandom % f.size()] ^= 8'(1 << ($urandom % 8));
      rx_frame(f, 1);
      idle($urandom % 3);
    end
    idle(3);

    running = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule